// File: doc/BRIEF.md
# Windowed watchdog reset supervisor

This block drives an active-low system reset from two causes: a supply-good flag that is already synchronous to the clock, and a window watchdog that watches falling edges on an asynchronous kick line. Each falling kick edge is timed against a watchdog period. The period is split into a closed window, where a kick comes too soon, and an open window, where a kick is expected. A kick in the closed window, or no kick by the end of the period, is a fault. A fault, or a low supply-good flag, holds the system reset low for a reset timeout. After that time the reset releases and the watchdog counts again from zero.

The period, the window split and the reset timeout come from static inputs. The block captures them only while its own synchronous reset is held low, so changes made later have no effect. Every kick classification and every late timeout produces a one-cycle event pulse with a good or bad flag. All times are counted in clock cycles.

Top module: `wdog_reset_supervisor`

## Requirements
- R1: While `rst_n` is low, `sys_rst_n` and `evt_valid` are low. The values on `period_in`, `win_sel` and `timeout_in` are captured at each clock edge of that time.
- R2: Each clock edge that samples `supply_ok` low drives `sys_rst_n` low. After `supply_ok` returns high, `sys_rst_n` rises at the (T+1)-th clock edge that samples it high, where T is the captured timeout. The same count applies after `rst_n` is released.
- R3: The closed window length C depends on `win_sel` and the captured period P (integer division). `win_sel` = 1 gives C = P/2, an open window of 50%. `win_sel` = 2 gives C = P/4, an open window of 75%. `win_sel` = 0 or 3 gives C = 0, a plain timeout. The kick line passes two synchronizer flops. A kick that falls just after clock edge n, counted from the reference edge, is classified with elapsed count n+2 at edge n+3. The reference edge is the edge of the release or of the last good event.
- R4: A kick with elapsed count below C is an early fault. At the classifying edge, `evt_valid` goes high with `evt_good` = 0 and `sys_rst_n` goes low. `sys_rst_n` then stays low for exactly T+1 cycles.
- R5: A kick with elapsed count from C through P-1 is good, including elapsed count exactly C. It gives `evt_valid` with `evt_good` = 1, and `sys_rst_n` stays high. The reference edge moves to the classifying edge.
- R6: If no kick is classified by elapsed count P-1, a late fault occurs at clock edge P after the reference edge. It gives `evt_valid` with `evt_good` = 0, and `sys_rst_n` is low for T+1 cycles. A kick classified at elapsed count P-1 wins over the late fault.
- R7: While `sys_rst_n` is low, kick edges are ignored and give no event. The watchdog restarts from zero at the release edge.
- R8: A captured period of zero disables the watchdog. No event occurs, and only `supply_ok` drives `sys_rst_n`.
- R9: Changes to `period_in`, `win_sel` or `timeout_in` while `rst_n` is high do not change the classification or the reset length.
- R10: `evt_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset; configuration is captured while low |
| supply_ok | input | 1 | Synchronous supply-good flag, high when the supply is good |
| kick | input | 1 | Asynchronous watchdog kick; falling edges are evaluated |
| period_in | input | PW | Watchdog period in cycles; zero disables the watchdog |
| win_sel | input | 2 | Window split select: 0/3 plain timeout, 1 half open, 2 three-quarter open |
| timeout_in | input | TW | Reset timeout T in cycles |
| sys_rst_n | output | 1 | Active-low system reset |
| evt_valid | output | 1 | One-cycle pulse per kick classification or late timeout |
| evt_good | output | 1 | High with `evt_valid` when the kick was good |

## Verification
The bench uses the default 16-bit widths. It runs with a period of 20 cycles and a timeout of 6 cycles. Both split modes then give whole-number closed windows of 10 and 5 cycles, so the bench can test the cycle just below each window edge and the cycle on it, as well as the last legal cycle against the late timeout. A second reset with a period of zero covers the disabled case. Changing the inputs after reset shows that they are captured only while the block reset is low.

// File: rtl/wdr_pkg.sv
// Shared definitions for the windowed watchdog reset supervisor.
// Assumes nothing beyond a synthesizable two-bit select encoding.
package wdr_pkg;
    // Window split select encoding; any other code behaves as OPEN_ALL.
    typedef enum logic [1:0] {
        OPEN_ALL  = 2'd0,
        OPEN_HALF = 2'd1,
        OPEN_3Q   = 2'd2
    } win_split_e;

    // Idle level of the kick line, used for synchronizer reset.
    localparam logic KICK_IDLE = 1'b1;
endpackage

// File: rtl/kick_edge_sync.sv
// Kick synchronizer and falling-edge detector.
// A chain of STAGES flops brings the asynchronous kick into the clock
// domain. One more flop gives the previous level, and 'fall' pulses for
// one cycle when the synchronized level goes from high to low.
// Assumes the kick line idles high.
module kick_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_async,
    output logic fall
);
    import wdr_pkg::*;

    logic [STAGES:0] chain;
    logic            prev;

    assign chain[0] = kick_async;

    // One flop per synchronizer stage.
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[i+1] <= KICK_IDLE;
            else        chain[i+1] <= chain[i];
        end
    end

    // Delayed copy of the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= KICK_IDLE;
        else        prev <= chain[STAGES];
    end

    assign fall = prev & ~chain[STAGES];

    // R3: a detected edge lasts a single cycle.
    a_r3_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/wd_window_timer.sv
// Window watchdog counter and kick classifier.
// It counts cycles since the reference edge while the watchdog is running,
// meaning the reset is released and the period is nonzero. A falling kick
// before the closed length is early, a kick from there through period-1
// is good, and no kick by period-1 is late. 'fault' is combinational so
// the reset stretcher registers it together with the event outputs.
// Assumes period and closed are static while running, with closed < period.
module wd_window_timer #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold,
    input  logic          fall,
    input  logic [PW-1:0] period,
    input  logic [PW-1:0] closed,
    output logic          fault,
    output logic          evt_valid,
    output logic          evt_good
);
    localparam logic [PW-1:0] ONE = {{(PW-1){1'b0}}, 1'b1};

    logic [PW-1:0] cnt;
    logic          running;
    logic          early;
    logic          good;
    logic          late;

    // Classify the current cycle; a kick wins over the late timeout.
    always_comb begin
        running = !hold && (period != '0);
        early   = running && fall && (cnt < closed);
        good    = running && fall && !(cnt < closed);
        late    = running && !fall && (cnt == period - ONE);
        fault   = early || late;
    end

    // Elapsed-cycle counter, cleared when held, on a kick, or on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt <= '0;
        else if (!running || fall || late)  cnt <= '0;
        else                                cnt <= cnt + ONE;
    end

    // Registered event pulse with its good/bad flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_good  <= 1'b0;
        end else begin
            evt_valid <= early || good || late;
            evt_good  <= good;
        end
    end

    // R7: no classification while the system reset is held.
    a_r7_quiet_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !evt_valid);
    // R6: the count never passes the period end while running.
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt < period));
    // R8: a zero period yields no events.
    a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0) |=> !evt_valid);
    // R10: events are single-cycle pulses.
    a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> !evt_valid);
endmodule

// File: rtl/rst_stretch.sv
// Reset stretcher.
// A low supply flag or a watchdog fault loads the timeout count and
// asserts 'hold'. The count then falls by one per cycle, and 'hold' drops
// on the cycle after it reaches zero, so the reset stays low for
// timeout+1 cycles after the last cause. During block reset the count is
// loaded from the live timeout input.
module rst_stretch #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          fault,
    input  logic [TW-1:0] tmo_live,
    input  logic [TW-1:0] tmo_cfg,
    output logic          hold
);
    localparam logic [TW-1:0] ONE = {{(TW-1){1'b0}}, 1'b1};

    logic [TW-1:0] rcnt;

    // Load on any cause, count down while held, release at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold <= 1'b1;
            rcnt <= tmo_live;
        end else if (!supply_ok || fault) begin
            hold <= 1'b1;
            rcnt <= tmo_cfg;
        end else if (hold) begin
            if (rcnt == '0) hold <= 1'b0;
            else            rcnt <= rcnt - ONE;
        end
    end

    // R2: a low supply sample holds reset at the next cycle.
    a_r2_supply_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> hold);
    // R4: a fault holds reset at the next cycle.
    a_r4_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> hold);
    // R2: the remaining count never exceeds the captured timeout.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rcnt <= tmo_cfg);
endmodule

// File: rtl/wdog_reset_supervisor.sv
// Windowed watchdog reset supervisor, top level.
// It captures the configuration while rst_n is low, derives the closed
// window from the split select, and joins the kick synchronizer, the
// window timer and the reset stretcher. sys_rst_n is low while the
// stretcher holds.
// Assumes supply_ok is synchronous to clk and kick idles high.
module wdog_reset_supervisor #(
    parameter int PW          = 16,
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          kick,
    input  logic [PW-1:0] period_in,
    input  logic [1:0]    win_sel,
    input  logic [TW-1:0] timeout_in,
    output logic          sys_rst_n,
    output logic          evt_valid,
    output logic          evt_good
);
    import wdr_pkg::*;

    logic [PW-1:0] cfg_period;
    logic [1:0]    cfg_sel;
    logic [TW-1:0] cfg_tmo;
    logic [PW-1:0] closed_len;
    logic          fall;
    logic          fault;
    logic          hold;

    // Configuration capture, only during block reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_period <= period_in;
            cfg_sel    <= win_sel;
            cfg_tmo    <= timeout_in;
        end
    end

    // Closed window length from the captured split select.
    always_comb begin
        case (cfg_sel)
            OPEN_HALF: closed_len = cfg_period >> 1;
            OPEN_3Q:   closed_len = cfg_period >> 2;
            default:   closed_len = '0;
        endcase
    end

    kick_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick_async (kick),
        .fall       (fall)
    );

    wd_window_timer #(.PW(PW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .fall      (fall),
        .period    (cfg_period),
        .closed    (closed_len),
        .fault     (fault),
        .evt_valid (evt_valid),
        .evt_good  (evt_good)
    );

    rst_stretch #(.TW(TW)) u_stretch (
        .clk       (clk),
        .rst_n     (rst_n),
        .supply_ok (supply_ok),
        .fault     (fault),
        .tmo_live  (timeout_in),
        .tmo_cfg   (cfg_tmo),
        .hold      (hold)
    );

    assign sys_rst_n = ~hold;

    // R4: a bad event coincides with reset going low.
    a_r4_bad_event_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_good) |-> !sys_rst_n);
    // R5: a good event with the supply good keeps reset released.
    a_r5_good_event_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_good && $past(supply_ok)) |-> sys_rst_n);
endmodule

// File: tb/tb_wdog_reset_supervisor.sv
// Directed bench for the windowed watchdog reset supervisor.
module tb_wdog_reset_supervisor;
    localparam int PW = 16;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          supply_ok = 1'b1;
    logic          kick = 1'b1;
    logic [PW-1:0] period_in = '0;
    logic [1:0]    win_sel = '0;
    logic [TW-1:0] timeout_in = '0;
    logic          sys_rst_n;
    logic          evt_valid;
    logic          evt_good;

    int n_checks = 0;
    int n_fail = 0;
    int cur_t = 0;
    int cur_p = 0;
    int since_ref = 0;
    bit done = 1'b0;

    wdog_reset_supervisor #(.PW(PW), .TW(TW), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .kick(kick),
        .period_in(period_in), .win_sel(win_sel), .timeout_in(timeout_in),
        .sys_rst_n(sys_rst_n), .evt_valid(evt_valid), .evt_good(evt_good)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    // Count reset-low cycles starting at the current low sample; optionally wiggle kick.
    task automatic measure_low(input string tag, input bit wiggle);
        int lows = 1;
        bit saw_evt = 1'b0;
        if (wiggle) kick = 1'b0;
        for (int i = 0; i < 200; i++) begin
            tick;
            if (wiggle && lows <= 4) kick = ~kick;
            if (wiggle && lows > 4) kick = 1'b1;
            if (sys_rst_n) break;
            lows++;
            if (evt_valid) saw_evt = 1'b1;
        end
        kick = 1'b1;
        check(lows == cur_t + 1, tag, lows, cur_t + 1);
        if (wiggle) check(!saw_evt, "R7 kick ignored in hold", int'(saw_evt), 0);
        since_ref = 0;
    endtask

    task automatic do_reset(input int p, input int s, input int t);
        int edges = 0;
        rst_n = 1'b0;
        period_in = PW'(p);
        win_sel = 2'(s);
        timeout_in = TW'(t);
        cur_p = p;
        cur_t = t;
        repeat (3) tick;
        check(!sys_rst_n && !evt_valid, "R1 reset state", int'({sys_rst_n, evt_valid}), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 200; i++) begin
            tick;
            edges++;
            if (sys_rst_n) break;
        end
        check(edges == t + 1, "R2 power-up release", edges, t + 1);
        since_ref = 0;
    endtask

    // Drive a kick just after edge n from the reference; check class and timing.
    task automatic kick_test(input int n, input bit exp_good, input string tag);
        int edges = since_ref;
        while (edges < n) begin
            tick;
            edges++;
        end
        kick = 1'b0;
        for (int i = 0; i < 200; i++) begin
            tick;
            edges++;
            if (evt_valid) break;
        end
        kick = 1'b1;
        check(edges == n + 3, {tag, " event edge"}, edges, n + 3);
        check(evt_good == exp_good, {tag, " class"}, int'(evt_good), int'(exp_good));
        if (exp_good) begin
            check(sys_rst_n, {tag, " reset stays high"}, int'(sys_rst_n), 1);
            since_ref = 0;
            tick;
            since_ref = 1;
            check(!evt_valid, "R10 single pulse", int'(evt_valid), 0);
        end else begin
            check(!sys_rst_n, {tag, " reset low"}, int'(sys_rst_n), 0);
            measure_low({tag, " reset length"}, 1'b0);
        end
    endtask

    task automatic late_test(input string tag, input bit wiggle);
        int edges = since_ref;
        for (int i = 0; i < 500; i++) begin
            tick;
            edges++;
            if (evt_valid) break;
        end
        check(edges == cur_p, {tag, " late edge"}, edges, cur_p);
        check(!evt_good && !sys_rst_n, {tag, " late is bad"}, int'({evt_good, sys_rst_n}), 0);
        measure_low({tag, " reset length"}, wiggle);
    endtask

    task automatic supply_test;
        int edges = 0;
        bit saw_evt = 1'b0;
        tick;
        supply_ok = 1'b0;
        tick;
        check(!sys_rst_n, "R2 supply low drops reset", int'(sys_rst_n), 0);
        repeat (2) tick;
        supply_ok = 1'b1;
        for (int i = 0; i < 200; i++) begin
            tick;
            edges++;
            if (evt_valid) saw_evt = 1'b1;
            if (sys_rst_n) break;
        end
        check(edges == cur_t + 1, "R2 supply release", edges, cur_t + 1);
        check(!saw_evt, "R7 no event in supply hold", int'(saw_evt), 0);
        since_ref = 0;
    endtask

    task automatic disabled_test;
        bit bad = 1'b0;
        for (int i = 0; i < 80; i++) begin
            tick;
            if (i % 8 == 0) kick = ~kick;
            if (evt_valid || !sys_rst_n) bad = 1'b1;
        end
        kick = 1'b1;
        check(!bad, "R8 disabled watchdog quiet", int'(bad), 0);
    endtask

    initial begin
        // Half-open window: P=20, C=10
        do_reset(20, 1, 6);
        kick_test(8, 1'b1, "R5 boundary good (R3 half)");
        kick_test(7, 1'b0, "R4 early half");
        kick_test(12, 1'b1, "R5 mid good");
        late_test("R6", 1'b1);
        late_test("R7 restart from zero", 1'b0);
        supply_test();
        kick_test(9, 1'b1, "R5 after supply");
        // Three-quarter open window: C=5
        do_reset(20, 2, 6);
        kick_test(3, 1'b1, "R5 boundary good (R3 3q)");
        kick_test(2, 1'b0, "R4 early 3q");
        // Plain timeout: C=0
        do_reset(20, 0, 6);
        kick_test(1, 1'b1, "R3 plain earliest good");
        kick_test(17, 1'b1, "R6 kick beats late");
        late_test("R6 plain", 1'b0);
        // Inputs changed after reset must be ignored
        do_reset(20, 1, 6);
        win_sel = 2'd0;
        period_in = PW'(40);
        timeout_in = TW'(1);
        kick_test(7, 1'b0, "R9 config held");
        // Zero period
        do_reset(0, 1, 6);
        disabled_test();
        supply_test();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule